// File: doc/BRIEF.md
# Nonvolatile Register Bank Controller

This block holds a small bank of four 6-bit setting registers that stand in for nonvolatile storage behind a digitally controlled wiper. A command port issues one operation per strobe. The operation is either a read of a selected register, a host write of a new value, a copy of a register into the wiper, or a save of the present wiper value into a register. Each store into the bank is treated as a slow nonvolatile write. The store opens a busy window that lasts a parameterised number of clock cycles. During that window the controller refuses every command, and the selected register changes only when the window closes.

An active-low protect input blocks all stores. A blocked store is still acknowledged, but it starts no busy window and leaves the bank as it was. Reset loads the bank with a parameterised image, which models the contents the cells held at power-up. In the first cycle after reset the controller pushes register 0 to the wiper through the same load pulse that a copy command uses.

Top module: `nvbank_ctrl`

## Requirements
- R1: A read command accepted in idle raises `rd_valid` for exactly one cycle, starting the cycle after the strobe, with `rd_data` equal to the register selected by `cmd_idx`. `rd_valid` and `wpr_load` are never high together.
- R2: A host write changes the target register only when its busy window ends. A read issued after the window returns the written value.
- R3: An accepted store with `wp_n` high holds `busy` high for exactly `WR_CYCLES` consecutive cycles, starting the cycle after the strobe.
- R4: While `busy` is high, every command is ignored. There is no `cmd_ack`, no `rd_valid` and no `wpr_load`, and the bank contents do not change.
- R5: A store issued with `wp_n` low is acknowledged, raises no `busy`, and leaves every register unchanged.
- R6: While `rst` is high, `busy` is 1 and `cmd_ack`, `rd_valid` and `wpr_load` are 0. The bank takes `INIT_IMAGE`, with register i in bits [6i+5:6i]. In the first cycle after reset is released, `wpr_load` pulses once with `wpr_value` equal to register 0, and `busy` drops.
- R7: A load command accepted in idle pulses `wpr_load` for one cycle, starting the cycle after the strobe, with `wpr_value` equal to the selected register. It raises no `busy`.
- R8: A save command stores the `wiper_in` value sampled on its strobe cycle. Later changes of `wiper_in` have no effect on what is stored.
- R9: `cmd_op` is encoded as 00 read, 01 write (`cmd_data`), 10 load register into wiper, 11 save wiper into register. Bit 0 set marks a store.
- R10: Every command strobed while `busy` is low gives a one-cycle `cmd_ack` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | Operation code |
| cmd_idx | input | 2 | Register index |
| cmd_data | input | 6 | Value for a host write |
| wiper_in | input | 6 | Current wiper value for a save |
| wp_n | input | 1 | Store enable; low blocks stores |
| cmd_ack | output | 1 | Command accepted |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 6 | Read data |
| busy | output | 1 | Nonvolatile write in progress or recall pending |
| wpr_load | output | 1 | Load pulse toward the wiper |
| wpr_value | output | 6 | Value to load into the wiper |

## Verification
The bench measures the busy window on every store. A timer that is off by one would show a window of `WR_CYCLES` plus or minus one. A strobe is injected on the first busy cycle. A controller that does not gate commands while busy would acknowledge it, return read data, or corrupt a register that a later read exposes. Stores under protect are followed by reads. A design that ignores `wp_n` would show busy or a changed value. Saves alter `wiper_in` right after the strobe, so a design that samples the wiper late stores the wrong value. The recall pulse after reset is checked against the image, which catches a missing pulse or a recall from the wrong register.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    parameter int CELL_W    = 6;
    parameter int NUM_CELLS = 4;
    parameter int IDX_W     = $clog2(NUM_CELLS);
    parameter int IMG_W     = NUM_CELLS * CELL_W;

    typedef logic [CELL_W-1:0] cell_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LOAD  = 2'b10,
        OP_SAVE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_RECALL = 2'b00,
        ST_IDLE   = 2'b01,
        ST_WRITE  = 2'b10
    } state_e;

    typedef struct packed {
        idx_t  idx;
        cell_t data;
    } pend_t;

    function automatic logic op_stores(op_e op);
        return op[0];
    endfunction

    function automatic cell_t image_cell(logic [IMG_W-1:0] img, int i);
        return img[i*CELL_W +: CELL_W];
    endfunction
endpackage

// File: rtl/nvb_cells.sv
module nvb_cells
    import nvb_pkg::*;
#(
    parameter logic [IMG_W-1:0] INIT_IMAGE = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  wr_idx,
    input  cell_t wr_data,
    input  idx_t  rd_idx,
    output cell_t rd_word
);
    logic [NUM_CELLS-1:0][CELL_W-1:0] flat;

    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        cell_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= image_cell(INIT_IMAGE, g);
            else if (we && wr_idx == idx_t'(g))
                q <= wr_data;
        end
        assign flat[g] = q;
    end

    assign rd_word = flat[rd_idx];
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
    parameter int WR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(WR_CYCLES - 1);
        end else if (run) begin
            if (cnt == '0)
                run <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);
endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cmd_valid,
    input  op_e   op,
    input  idx_t  idx,
    input  cell_t cmd_data,
    input  cell_t wiper_in,
    input  logic  wp_n,
    input  cell_t rd_word,
    input  logic  tmr_done,
    output logic  busy,
    output idx_t  rd_idx,
    output logic  tmr_start,
    output logic  we,
    output idx_t  wr_idx,
    output cell_t wr_data,
    output logic  cmd_ack,
    output logic  rd_valid,
    output cell_t rd_data,
    output logic  wpr_load,
    output cell_t wpr_value
);
    state_e st;
    pend_t  pend;
    logic   accept;

    assign accept    = cmd_valid && (st == ST_IDLE);
    assign tmr_start = accept && op_stores(op) && wp_n;
    assign busy      = (st != ST_IDLE);
    assign rd_idx    = (st == ST_RECALL) ? '0 : idx;
    assign we        = (st == ST_WRITE) && tmr_done;
    assign wr_idx    = pend.idx;
    assign wr_data   = pend.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RECALL;
            pend      <= '0;
            cmd_ack   <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            wpr_load  <= 1'b0;
            wpr_value <= '0;
        end else begin
            cmd_ack  <= accept;
            rd_valid <= 1'b0;
            wpr_load <= 1'b0;
            case (st)
                ST_RECALL: begin
                    wpr_load  <= 1'b1;
                    wpr_value <= rd_word;
                    st        <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (accept) begin
                        case (op)
                            OP_READ: begin
                                rd_valid <= 1'b1;
                                rd_data  <= rd_word;
                            end
                            OP_LOAD: begin
                                wpr_load  <= 1'b1;
                                wpr_value <= rd_word;
                            end
                            default: begin
                                if (wp_n) begin
                                    pend.idx  <= idx;
                                    pend.data <= (op == OP_WRITE) ? cmd_data : wiper_in;
                                    st        <= ST_WRITE;
                                end
                            end
                        endcase
                    end
                end
                ST_WRITE: begin
                    if (tmr_done)
                        st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nvbank_ctrl.sv
module nvbank_ctrl
    import nvb_pkg::*;
#(
    parameter int               WR_CYCLES  = 16,
    parameter logic [IMG_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [CELL_W-1:0] cmd_data,
    input  logic [CELL_W-1:0] wiper_in,
    input  logic              wp_n,
    output logic              cmd_ack,
    output logic              rd_valid,
    output logic [CELL_W-1:0] rd_data,
    output logic              busy,
    output logic              wpr_load,
    output logic [CELL_W-1:0] wpr_value
);
    idx_t  rd_idx, wr_idx;
    cell_t rd_word, wr_data;
    logic  we, tmr_start, tmr_done;

    nvb_cells #(.INIT_IMAGE(INIT_IMAGE)) cells_i (
        .clk(clk), .rst(rst), .we(we), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    nvb_timer #(.WR_CYCLES(WR_CYCLES)) timer_i (
        .clk(clk), .rst(rst), .start(tmr_start), .done(tmr_done)
    );

    nvb_seq seq_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .op(op_e'(cmd_op)),
        .idx(cmd_idx), .cmd_data(cmd_data), .wiper_in(wiper_in), .wp_n(wp_n),
        .rd_word(rd_word), .tmr_done(tmr_done), .busy(busy), .rd_idx(rd_idx),
        .tmr_start(tmr_start), .we(we), .wr_idx(wr_idx), .wr_data(wr_data),
        .cmd_ack(cmd_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .wpr_load(wpr_load), .wpr_value(wpr_value)
    );
endmodule

// File: rtl/nvb_chk.sv
module nvb_chk #(
    parameter int WR_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       wp_n,
    input logic       cmd_ack,
    input logic       rd_valid,
    input logic       busy,
    input logic       wpr_load
);
    localparam int LEN_W = $clog2(WR_CYCLES + 2) + 1;
    logic [LEN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1'b1;
    end

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        run_len <= LEN_W'(WR_CYCLES));

    assert_store_starts_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && wp_n && cmd_op[0]) |=> busy);

    assert_no_ack_when_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> !cmd_ack);

    assert_protect_no_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && !wp_n && cmd_op[0]) |=> !busy);

    assert_recall_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> wpr_load);

    assert_single_output_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_valid, wpr_load}));

    assert_ack_follows_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> cmd_ack);
endmodule

bind nvbank_ctrl nvb_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wp_n(wp_n),
    .cmd_ack(cmd_ack), .rd_valid(rd_valid), .busy(busy), .wpr_load(wpr_load)
);

// File: tb/nvbank_ctrl_tb.sv
`timescale 1ns/1ps
module nvbank_ctrl_tb_top;
    localparam int          WR     = 5;
    localparam logic [23:0] IMG    = {6'd51, 6'd7, 6'd63, 6'd22};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [1:0] cmd_idx = 2'b00;
    logic [5:0] cmd_data = 6'd0;
    logic [5:0] wiper_in = 6'd0;
    logic       wp_n = 1'b1;
    logic       cmd_ack, rd_valid, busy, wpr_load;
    logic [5:0] rd_data, wpr_value;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [5:0] exp_cell [4];

    always #4 clk = ~clk;

    nvbank_ctrl #(.WR_CYCLES(WR), .INIT_IMAGE(IMG)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .wiper_in(wiper_in), .wp_n(wp_n),
        .cmd_ack(cmd_ack), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .wpr_load(wpr_load), .wpr_value(wpr_value)
    );

    function automatic logic [5:0] img_cell(int i);
        return IMG[i*6 +: 6];
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [1:0] idx,
                           input logic [5:0] data, input logic [5:0] wip, input logic wp);
        int   n;
        logic stores;
        logic [5:0] stored;
        stores = op[0];
        stored = (op == 2'b01) ? data : wip;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
        cmd_data = data; wiper_in = wip; wp_n = wp;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wiper_in  = ~wip;
        check(cmd_ack == 1'b1, "R10 ack after idle command", cmd_ack, 1);
        case (op)
            2'b00: check(rd_valid && rd_data == exp_cell[idx], "R1/R9 read data",
                         rd_data, exp_cell[idx]);
            2'b10: check(wpr_load && wpr_value == exp_cell[idx], "R7/R9 load to wiper",
                         wpr_value, exp_cell[idx]);
            default: ;
        endcase
        if (!stores) begin
            check(busy == 1'b0, "R7 no busy for non-store", busy, 0);
        end else if (!wp) begin
            check(busy == 1'b0, "R5 protected store no busy", busy, 0);
        end else begin
            n = 0;
            while (busy && n < 1000) begin
                n++;
                if (n == 1) begin
                    cmd_valid = 1'b1;
                    cmd_op    = 2'($urandom_range(0, 3));
                    cmd_idx   = 2'($urandom_range(0, 3));
                    cmd_data  = 6'($urandom);
                    wp_n      = 1'b1;
                end
                @(posedge clk);
                @(negedge clk);
                if (n == 1) begin
                    cmd_valid = 1'b0;
                    check(!cmd_ack && !rd_valid && !wpr_load, "R4 command during busy ignored",
                          {cmd_ack, rd_valid, wpr_load}, 0);
                end
            end
            check(n == WR, "R3 busy window length", n, WR);
            exp_cell[idx] = stored;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) exp_cell[i] = img_cell(i);

        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R6 busy during reset", busy, 1);
        check(!cmd_ack && !rd_valid && !wpr_load, "R6 outputs quiet in reset",
              {cmd_ack, rd_valid, wpr_load}, 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(wpr_load == 1'b1, "R6 recall pulse", wpr_load, 1);
        check(wpr_value == img_cell(0), "R6 recall value is register 0", wpr_value, img_cell(0));
        check(busy == 1'b0, "R6 busy drops after recall", busy, 0);
        @(negedge clk);
        check(wpr_load == 1'b0, "R6 recall pulse is single", wpr_load, 0);

        for (int i = 0; i < 4; i++) run_cmd(2'b00, 2'(i), 6'd0, 6'd0, 1'b1);

        run_cmd(2'b01, 2'd2, 6'd45, 6'd0, 1'b1);
        run_cmd(2'b00, 2'd2, 6'd0, 6'd0, 1'b1);
        check(rd_data == 6'd45, "R2 written value after window", rd_data, 45);

        run_cmd(2'b11, 2'd3, 6'd0, 6'd12, 1'b1);
        run_cmd(2'b00, 2'd3, 6'd0, 6'd0, 1'b1);
        check(rd_data == 6'd12, "R8 save uses strobe-cycle wiper", rd_data, 12);

        run_cmd(2'b01, 2'd1, 6'd0, 6'd0, 1'b0);
        run_cmd(2'b11, 2'd0, 6'd0, 6'd9, 1'b0);
        run_cmd(2'b00, 2'd1, 6'd0, 6'd0, 1'b1);
        check(rd_data == img_cell(1), "R5 protected write left data", rd_data, img_cell(1));
        run_cmd(2'b00, 2'd0, 6'd0, 6'd0, 1'b1);
        check(rd_data == img_cell(0), "R5 protected save left data", rd_data, img_cell(0));

        run_cmd(2'b10, 2'd1, 6'd0, 6'd0, 1'b1);

        run_cmd(2'b01, 2'd0, 6'd63, 6'd0, 1'b1);
        run_cmd(2'b01, 2'd3, 6'd0, 6'd0, 1'b1);
        run_cmd(2'b10, 2'd0, 6'd0, 6'd0, 1'b1);
        run_cmd(2'b10, 2'd3, 6'd0, 6'd0, 1'b1);

        for (int k = 0; k < 300; k++) begin
            run_cmd(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    6'($urandom), 6'($urandom), ($urandom_range(0, 3) != 0));
        end

        for (int i = 0; i < 4; i++) run_cmd(2'b00, 2'(i), 6'd0, 6'd0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule